// File: doc/BRIEF.md
# PSRAM Identity Probe Sequencer

This block interrogates a serial pseudo-static RAM once after reset, and again on each start pulse. It drives the memory's serial lines directly, one byte at a time. First it sends a reset-enable command in its own chip-select frame so that the device is in a known state. It then releases chip select for a guard interval and runs a full-duplex identity read. Two of the bytes received during that read are kept: the known-good-die code and the extended identity byte.

From those two bytes the block decodes the device capacity. It compares the capacity with the size the chip was built to expect and reports the result as flags: done, ok, size mismatch and device not found. It also outputs the decoded capacity in bytes. The serial clock is a slow division of the system clock so that the probe works before any timing tuning has been done. The flags stay valid while the block is idle, until the next start pulse.

Top module: `psram_id_probe`

## Requirements
- R1: A probe starts by itself on the first clock after reset is released. While reset is high, `cs_n_o` is 1, `sclk_o` is 0, `io_oe_o` is 0 and `done_o` is 0.
- R2: The first frame carries command 0xF5 over two SCLK cycles on `io_o[3:0]`, high nibble first (nibble 0xF, then 0x5), with `io_oe_o` = 4'hF. Chip select is released when the frame ends, and anything received in that frame is discarded.
- R3: Between the reset-enable frame and the identity frame, `cs_n_o` stays high for at least CLK_DIV system clocks. Each probe makes exactly two chip-select frames.
- R4: The identity frame has 7 byte transfers. Transfer 0 sends 0x9F and transfers 1 to 6 send 0xFF. Each byte goes out MSB first on `io_o[0]` with `io_oe_o` = 4'h1.
- R5: Received bits are taken from `mem_miso_i` at each rising SCLK edge, MSB first. The byte received in transfer 5 is the known-good-die code and the byte received in transfer 6 is the extended identity byte.
- R6: When the die code is good, the capacity is decoded as follows. An extended identity byte of exactly 0x26, or one whose bits [7:5] equal 2, gives 8 MB (0x800000). Bits [7:5] equal to 0 give 2 MB (0x200000). Bits [7:5] equal to 1 give 4 MB (0x400000). Any other value gives 1 MB (0x100000).
- R7: When the die code is not 0x5D, `notfound_o` is 1 and `size_o` is 0.
- R8: `mismatch_o` is 1 exactly when the decoded size differs from the EXP_SIZE parameter, and `ok_o` is its complement while `done_o` is 1.
- R9: SCLK idles low. Each high phase lasts CLK_DIV/2 system clocks, and each low phase inside a frame lasts at least CLK_DIV/2 system clocks.
- R10: `done_o` and the result flags hold until the next start pulse, which clears `done_o` on the following clock. A start pulse that arrives while a probe is running has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to run a new probe |
| mem_miso_i | input | 1 | Serial data from the memory (IO1) |
| sclk_o | output | 1 | Serial clock to the memory |
| cs_n_o | output | 1 | Active-low chip select |
| io_o | output | 4 | Serial data lines to the memory |
| io_oe_o | output | 4 | Per-line output enable |
| done_o | output | 1 | Probe finished and flags are valid |
| ok_o | output | 1 | Device found with the expected size |
| mismatch_o | output | 1 | Decoded size differs from the expected size |
| notfound_o | output | 1 | Known-good-die code was wrong |
| size_o | output | SZ_W | Decoded capacity in bytes |

## Verification
The assertions assume that `start_i` is a single-cycle pulse and that CLK_DIV is even and at least 4. They also assume that `mem_miso_i` does not change in the system cycle in which the block samples it at a rising SCLK edge. The memory model in the bench respects this: it moves to the next response bit only one cycle after it sees SCLK rise, which leaves nearly half an SCLK period before the next sample. Start pulses are always issued for one cycle on the falling system-clock edge. The mid-run start is placed well inside a frame, so it can be distinguished from a start issued while the block is idle.

// File: rtl/psram_probe_pkg.sv
package psram_probe_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RSEL, ST_RBUSY, ST_GAP, ST_IDSEL, ST_IDBUSY, ST_EVAL
  } probe_st_e;

  localparam logic [7:0] CMD_RST_EN = 8'hF5;
  localparam logic [7:0] CMD_RD_ID  = 8'h9F;
  localparam logic [7:0] CMD_FILL   = 8'hFF;
  localparam logic [7:0] DIE_GOOD   = 8'h5D;
  localparam logic [7:0] EID_8M_ALT = 8'h26;
  localparam int         N_ID_XFER  = 7;
  localparam int         SLOT_KGD   = 5;
  localparam int         SLOT_EID   = 6;
endpackage

// File: rtl/probe_div.sv
module probe_div #(
  parameter int HALF = 15
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  logic [CW-1:0] cnt;

  assign tick = en && (cnt == CW'(HALF - 1));

  always_ff @(posedge clk) begin
    if (rst || !en || tick) cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/probe_shift.sv
module probe_shift #(
  parameter int HALF = 15
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       go,
  input  logic       quad,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       sclk,
  output logic [3:0] io_out,
  output logic [3:0] io_oe,
  output logic       busy,
  output logic       fin,
  output logic [7:0] rx_byte
);
  logic       tick;
  logic       quad_q;
  logic [7:0] tx_sh;
  logic [7:0] rx_sh;
  logic [3:0] bits_left;

  probe_div #(.HALF(HALF)) u_div (
    .clk (clk),
    .rst (rst),
    .en  (busy),
    .tick(tick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      fin       <= 1'b0;
      sclk      <= 1'b0;
      quad_q    <= 1'b0;
      tx_sh     <= '0;
      rx_sh     <= '0;
      bits_left <= '0;
    end else begin
      fin <= 1'b0;
      if (go && !busy) begin
        busy      <= 1'b1;
        sclk      <= 1'b0;
        quad_q    <= quad;
        tx_sh     <= tx_byte;
        bits_left <= quad ? 4'd2 : 4'd8;
      end else if (tick) begin
        sclk <= ~sclk;
        if (!sclk) begin
          rx_sh <= {rx_sh[6:0], miso};
        end else begin
          tx_sh     <= quad_q ? {tx_sh[3:0], 4'h0} : {tx_sh[6:0], 1'b0};
          bits_left <= bits_left - 1'b1;
          if (bits_left == 4'd1) begin
            busy <= 1'b0;
            fin  <= 1'b1;
          end
        end
      end
    end
  end

  assign rx_byte = rx_sh;
  assign io_out  = quad_q ? tx_sh[7:4] : {3'b000, tx_sh[7]};
  assign io_oe   = !busy ? 4'h0 : (quad_q ? 4'hF : 4'h1);

  p_sclk_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !sclk);
  p_oe_shape_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(io_oe) || io_oe == 4'hF);
  p_fin_ends_r9: assert property (@(posedge clk) disable iff (rst)
    fin |-> !busy && !sclk);
endmodule

// File: rtl/probe_size_dec.sv
module probe_size_dec
  import psram_probe_pkg::*;
#(
  parameter int SZ_W = 24
) (
  input  logic [7:0]      kgd,
  input  logic [7:0]      eid,
  output logic            found,
  output logic [SZ_W-1:0] size
);
  localparam logic [SZ_W-1:0] SZ_1M = SZ_W'(32'h0010_0000);

  always_comb begin
    found = (kgd == DIE_GOOD);
    if (!found)                                    size = '0;
    else if (eid == EID_8M_ALT || eid[7:5] == 3'd2) size = SZ_1M << 3;
    else if (eid[7:5] == 3'd0)                     size = SZ_1M << 1;
    else if (eid[7:5] == 3'd1)                     size = SZ_1M << 2;
    else                                           size = SZ_1M;
  end
endmodule

// File: rtl/psram_id_probe.sv
module psram_id_probe
  import psram_probe_pkg::*;
#(
  parameter int          CLK_DIV  = 30,
  parameter int          SZ_W     = 24,
  parameter int unsigned EXP_SIZE = 32'h0080_0000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_i,
  input  logic            mem_miso_i,
  output logic            sclk_o,
  output logic            cs_n_o,
  output logic [3:0]      io_o,
  output logic [3:0]      io_oe_o,
  output logic            done_o,
  output logic            ok_o,
  output logic            mismatch_o,
  output logic            notfound_o,
  output logic [SZ_W-1:0] size_o
);
  localparam int HALF = CLK_DIV / 2;
  localparam int GW   = $clog2(CLK_DIV + 1);

  probe_st_e       state;
  logic            kick;
  logic            go_q, quad_q;
  logic [7:0]      tx_q;
  logic [2:0]      idx;
  logic [GW-1:0]   gcnt;
  logic [7:0]      kgd_q, eid_q;
  logic            sh_busy, sh_fin;
  logic [7:0]      sh_rx;
  logic            dec_found;
  logic [SZ_W-1:0] dec_size;

  probe_shift #(.HALF(HALF)) u_shift (
    .clk    (clk),
    .rst    (rst),
    .go     (go_q),
    .quad   (quad_q),
    .tx_byte(tx_q),
    .miso   (mem_miso_i),
    .sclk   (sclk_o),
    .io_out (io_o),
    .io_oe  (io_oe_o),
    .busy   (sh_busy),
    .fin    (sh_fin),
    .rx_byte(sh_rx)
  );

  probe_size_dec #(.SZ_W(SZ_W)) u_dec (
    .kgd  (kgd_q),
    .eid  (eid_q),
    .found(dec_found),
    .size (dec_size)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      kick       <= 1'b1;
      go_q       <= 1'b0;
      quad_q     <= 1'b0;
      tx_q       <= '0;
      idx        <= '0;
      gcnt       <= '0;
      kgd_q      <= '0;
      eid_q      <= '0;
      cs_n_o     <= 1'b1;
      done_o     <= 1'b0;
      ok_o       <= 1'b0;
      mismatch_o <= 1'b0;
      notfound_o <= 1'b0;
      size_o     <= '0;
    end else begin
      go_q <= 1'b0;
      unique case (state)
        ST_IDLE: if (kick || start_i) begin
          kick       <= 1'b0;
          done_o     <= 1'b0;
          ok_o       <= 1'b0;
          mismatch_o <= 1'b0;
          notfound_o <= 1'b0;
          size_o     <= '0;
          state      <= ST_RSEL;
        end
        ST_RSEL: begin
          cs_n_o <= 1'b0;
          go_q   <= 1'b1;
          quad_q <= 1'b1;
          tx_q   <= CMD_RST_EN;
          state  <= ST_RBUSY;
        end
        ST_RBUSY: if (sh_fin) begin
          cs_n_o <= 1'b1;
          gcnt   <= '0;
          state  <= ST_GAP;
        end
        ST_GAP: begin
          gcnt <= gcnt + 1'b1;
          if (gcnt == GW'(CLK_DIV - 1)) state <= ST_IDSEL;
        end
        ST_IDSEL: begin
          cs_n_o <= 1'b0;
          idx    <= '0;
          go_q   <= 1'b1;
          quad_q <= 1'b0;
          tx_q   <= CMD_RD_ID;
          state  <= ST_IDBUSY;
        end
        ST_IDBUSY: if (sh_fin) begin
          if (idx == 3'(SLOT_KGD)) kgd_q <= sh_rx;
          if (idx == 3'(SLOT_EID)) eid_q <= sh_rx;
          if (idx == 3'(N_ID_XFER - 1)) begin
            cs_n_o <= 1'b1;
            state  <= ST_EVAL;
          end else begin
            idx  <= idx + 1'b1;
            go_q <= 1'b1;
            tx_q <= CMD_FILL;
          end
        end
        ST_EVAL: begin
          done_o     <= 1'b1;
          size_o     <= dec_size;
          notfound_o <= !dec_found;
          mismatch_o <= (dec_size != SZ_W'(EXP_SIZE));
          ok_o       <= (dec_size == SZ_W'(EXP_SIZE));
          state      <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_busy_in_frame_r3: assert property (@(posedge clk) disable iff (rst)
    sh_busy |-> !cs_n_o);
  p_done_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    done_o |-> cs_n_o && !sh_busy && !sclk_o);
  p_ok_excl_r8: assert property (@(posedge clk) disable iff (rst)
    ok_o |-> done_o && !mismatch_o);
  p_nf_zero_r7: assert property (@(posedge clk) disable iff (rst)
    notfound_o |-> size_o == '0);
  p_start_ignored_r10: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDBUSY && start_i && !sh_fin) |=> state == ST_IDBUSY);
  p_done_held_r10: assert property (@(posedge clk) disable iff (rst)
    (done_o && !start_i) |=> done_o);
endmodule

// File: tb/test_psram_id_probe.sv
module test_psram_id_probe;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 30;
  localparam int SZW        = 24;
  localparam int EXPSZ      = 32'h0080_0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic miso;
  logic sclk_o, cs_n_o, done_o, ok_o, mismatch_o, notfound_o;
  logic [3:0] io_o, io_oe_o;
  logic [SZW-1:0] size_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  psram_id_probe #(.CLK_DIV(DIV), .SZ_W(SZW), .EXP_SIZE(EXPSZ)) i_psram_id_probe (
    .clk(clk), .rst(rst), .start_i(start), .mem_miso_i(miso),
    .sclk_o(sclk_o), .cs_n_o(cs_n_o), .io_o(io_o), .io_oe_o(io_oe_o),
    .done_o(done_o), .ok_o(ok_o), .mismatch_o(mismatch_o),
    .notfound_o(notfound_o), .size_o(size_o)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // memory model state
  logic [55:0] resp = '0;
  int  cyc = 0, rise_k = 0, frame_total = 0;
  bit  id_frame = 0;
  logic sclk_q = 0, cs_q = 1;
  logic [3:0] nib0, nib1, oe_rst;
  logic [55:0] id_bits;
  bit  oe_bad = 0;
  int  t_rise = 0, t_fall = 0, t_cs_rise = 0, gap_last = 0;
  int  hi_min = 1000, hi_max = 0, lo_min = 1000;

  assign miso = (id_frame && rise_k < 56) ? resp[55 - rise_k] : 1'b0;

  always @(negedge clk) begin
    if (rst) begin
      frame_total <= 0; sclk_q <= 0; cs_q <= 1; rise_k <= 0; id_frame <= 0;
    end else begin
      cyc <= cyc + 1;
      sclk_q <= sclk_o;
      cs_q <= cs_n_o;
      if (cs_q && !cs_n_o) begin
        rise_k <= 0;
        frame_total <= frame_total + 1;
        id_frame <= frame_total[0];
        if (frame_total[0]) gap_last <= cyc - t_cs_rise;
        if (frame_total[0]) oe_bad <= 0;
      end
      if (!cs_q && cs_n_o) t_cs_rise <= cyc;
      if (!sclk_q && sclk_o) begin
        rise_k <= rise_k + 1;
        t_rise <= cyc;
        if (rise_k > 0 && cyc - t_fall < lo_min) lo_min <= cyc - t_fall;
        if (!id_frame) begin
          if (rise_k == 0) nib0 <= io_o; else nib1 <= io_o;
          oe_rst <= io_oe_o;
        end else begin
          id_bits <= {id_bits[54:0], io_o[0]};
          if (io_oe_o != 4'h1) oe_bad <= 1;
        end
      end
      if (sclk_q && !sclk_o) begin
        t_fall <= cyc;
        if (cyc - t_rise < hi_min) hi_min <= cyc - t_rise;
        if (cyc - t_rise > hi_max) hi_max <= cyc - t_rise;
      end
    end
  end

  task automatic chk(input bit c, input string rq, input longint act, input longint exp);
    n_chk++;
    if (!c) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", rq, act, exp);
    end
  endtask

  function automatic logic [55:0] mk_resp(input logic [7:0] kgd, input logic [7:0] eid);
    return {8'h00, 8'h12, 8'h34, 8'h56, 8'h0D, kgd, eid};
  endfunction

  task automatic wait_done();
    int n = 0;
    @(negedge clk);
    while (!done_o && n < 5000) begin @(negedge clk); n++; end
    chk(done_o, "R10 done reached", done_o, 1);
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic check_result(input string rq, input int exp_size, input bit exp_nf);
    chk(size_o == SZW'(exp_size), {rq, " size"}, size_o, exp_size);
    chk(notfound_o == exp_nf, "R7 notfound", notfound_o, exp_nf);
    chk(mismatch_o == (exp_size != EXPSZ), "R8 mismatch", mismatch_o, exp_size != EXPSZ);
    chk(ok_o == (exp_size == EXPSZ), "R8 ok", ok_o, exp_size == EXPSZ);
  endtask

  // R1, R2, R3, R4, R5, R9: auto run after reset, frame contents and timing
  task automatic t_reset_and_frames();
    resp = mk_resp(8'h5D, 8'h40);
    repeat (4) @(negedge clk);
    chk(cs_n_o == 1, "R1 cs_n in reset", cs_n_o, 1);
    chk(sclk_o == 0, "R1 sclk in reset", sclk_o, 0);
    chk(io_oe_o == 0, "R1 oe in reset", io_oe_o, 0);
    chk(done_o == 0, "R1 done in reset", done_o, 0);
    rst = 1'b0;
    wait_done();
    chk(frame_total == 2, "R3 two frames", frame_total, 2);
    chk(nib0 == 4'hF, "R2 first nibble", nib0, 4'hF);
    chk(nib1 == 4'h5, "R2 second nibble", nib1, 4'h5);
    chk(oe_rst == 4'hF, "R2 quad oe", oe_rst, 4'hF);
    chk(id_bits == {8'h9F, {6{8'hFF}}}, "R4 id bytes", id_bits, {8'h9F, {6{8'hFF}}});
    chk(!oe_bad, "R4 single-line oe", oe_bad, 0);
    chk(gap_last >= DIV, "R3 cs gap", gap_last, DIV);
    chk(hi_min == DIV/2 && hi_max == DIV/2, "R9 sclk high", hi_max, DIV/2);
    chk(lo_min >= DIV/2, "R9 sclk low", lo_min, DIV/2);
    check_result("R5 R6 8MB", 32'h0080_0000, 0);
  endtask

  task automatic t_probe(input string rq, input logic [7:0] kgd, input logic [7:0] eid,
                         input int exp_size, input bit exp_nf);
    int f0 = frame_total;
    resp = mk_resp(kgd, eid);
    pulse_start();
    chk(done_o == 0, "R10 start clears done", done_o, 0);
    wait_done();
    chk(frame_total - f0 == 2, "R3 frames per probe", frame_total - f0, 2);
    check_result(rq, exp_size, exp_nf);
  endtask

  // R10: a start during a run is ignored; done holds while idle
  task automatic t_start_mid_run();
    int f0 = frame_total;
    resp = mk_resp(8'h5D, 8'h20);
    pulse_start();
    repeat (600) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    wait_done();
    repeat (300) @(negedge clk);
    chk(frame_total - f0 == 2, "R10 mid-run start ignored", frame_total - f0, 2);
    chk(done_o == 1, "R10 done held", done_o, 1);
    check_result("R6 4MB", 32'h0040_0000, 0);
  endtask

  initial begin
    t_reset_and_frames();
    t_probe("R6 eid 0x26 8MB", 8'h5D, 8'h26, 32'h0080_0000, 0);
    t_probe("R6 2MB", 8'h5D, 8'h00, 32'h0020_0000, 0);
    t_probe("R6 1MB other", 8'h5D, 8'hE0, 32'h0010_0000, 0);
    t_probe("R7 bad die", 8'h55, 8'h40, 0, 1);
    t_probe("R5 slot 8MB", 8'h5D, 8'h5F, 32'h0080_0000, 0);
    t_start_mid_run();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule